// File: doc/BRIEF.md
# Keypad Matrix Scan Encoder

This block scans a grid of key switches with four column lines and four or five row lines. It turns a single key closure into a binary key code. The column lines are driven low one after another. Rows are active low and read high when no key is pressed. When a row reads low during a column's slot, the scan stops on that column and only that row is watched from then on. A debounce count of scan ticks then has to complete with the row still low. After that the code is captured and a data-available flag rises.

On release, the same debounce count must complete with the row high before the flag falls and scanning restarts. This rejects release bounce. It also gives two-key rollover: a second key pressed while the first is held is only seen after the first has been let go and debounced. The captured code is presented on a bus whose drive is gated by an active-low output enable.

The scan rate comes from a clock-enable divider and the debounce length from a tick count. Both are parameters. Row inputs pass through a two-flop synchroniser.

Top module: `keypad_encoder`

## Requirements
- R1: With NUM_ROWS=4 the code is 4 bits wide; with NUM_ROWS=5 it is 5 bits wide. The code of the key at row r and column c is r*4+c, where column c is the one whose col_no_o bit c is low.
- R2: Out of reset, col_no_o is 4'b1110. While no key is active, exactly one column bit is low, and the low bit moves from c to (c+1) mod 4 every TICK_DIV clock cycles.
- R3: From the scan tick on which a low row is detected until the key has been released and debounced, col_no_o does not change.
- R4: If several rows are low in the selected column at the detection tick, the lowest-numbered row is taken. Any other key pressed while a key is locked is ignored until the locked key has been released and debounced. After that, a key still held is scanned and encoded normally.
- R5: If the locked row reads high on any tick before the debounce count completes, the closure is dropped and scanning resumes. A closure shorter than (DEBOUNCE_TICKS-1)*TICK_DIV cycles never raises dav_o.
- R6: dav_o rises only after the locked row has stayed low for DEBOUNCE_TICKS further scan ticks. This is at least DEBOUNCE_TICKS*TICK_DIV cycles after the key closes, and the code is captured at that same moment.
- R7: After release, dav_o falls only once the row has stayed high for DEBOUNCE_TICKS scan ticks. If the key re-closes during that window, dav_o stays high and no new code is captured.
- R8: The captured code keeps its value after dav_o falls, until the next valid closure.
- R9: code_valid_o is high exactly when oe_ni is low. Only then does code_o carry the captured code; otherwise code_o is high impedance.
- R10: While rst_ni is low, dav_o is 0, the captured code is 0 and col_no_o is 4'b1110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| row_ni | input | NUM_ROWS | Row sense lines, active low |
| col_no | output | 4 | Column drive lines, one low at a time |
| oe_ni | input | 1 | Output enable, active low |
| code_o | output | CODE_W | Captured key code, high impedance when disabled |
| code_valid_o | output | 1 | High while code_o is driven |
| dav_o | output | 1 | Data available |

## Verification
The hardest state to reach is the release-debounce window with a second key already held. In that state the first key's lockout must hold while the row briefly reopens, and the second key must appear only once the window closes. The bench models the grid itself: each row line is computed from a matrix of pressed keys and the live column drive. Closures therefore appear only during their column's slot, as they would on a real keypad. Directed sequences overlap two presses, bounce the release shorter than the window, and press two rows of one column together. Random key choices and hold times then cover the rest of the code space.

// File: rtl/kpe_pkg.sv
package kpe_pkg;
  typedef enum logic [1:0] {
    ST_SCAN    = 2'd0,
    ST_PRESS   = 2'd1,
    ST_HELD    = 2'd2,
    ST_RELEASE = 2'd3
  } kpe_state_e;

  localparam int unsigned NUM_COLS = 4;
  localparam int unsigned COL_W    = 2;
endpackage

// File: rtl/kpe_tick_gen.sv
module kpe_tick_gen #(
  parameter int unsigned TICK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/kpe_row_sync.sv
module kpe_row_sync #(
  parameter int unsigned NUM_ROWS = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_ROWS-1:0] row_ni,
  output logic [NUM_ROWS-1:0] row_s_no
);
  logic [NUM_ROWS-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '1;
      sync_q <= '1;
    end else begin
      meta_q <= row_ni;
      sync_q <= meta_q;
    end
  end

  assign row_s_no = sync_q;
endmodule

// File: rtl/kpe_col_scan.sv
module kpe_col_scan
  import kpe_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [COL_W-1:0] col_idx_o,
  output logic [NUM_COLS-1:0] col_no
);
  logic [COL_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    idx_q <= '0;
    else if (adv_i) idx_q <= idx_q + 1'b1;
  end

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    assign col_no[c] = (idx_q != COL_W'(c));
  end

  assign col_idx_o = idx_q;
endmodule

// File: rtl/kpe_ctrl.sv
module kpe_ctrl
  import kpe_pkg::*;
#(
  parameter int unsigned NUM_ROWS       = 5,
  parameter int unsigned DEBOUNCE_TICKS = 3,
  parameter int unsigned CODE_W         = 5,
  parameter int unsigned ROW_W          = CODE_W - COL_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic [NUM_ROWS-1:0] row_s_ni,
  input  logic [COL_W-1:0]    col_idx_i,
  output logic                adv_o,
  output kpe_state_e          state_o,
  output logic [ROW_W-1:0]    lock_row_o,
  output logic [CODE_W-1:0]   code_o,
  output logic                dav_o
);
  localparam int unsigned DB_W = (DEBOUNCE_TICKS > 1) ? $clog2(DEBOUNCE_TICKS) : 1;
  localparam logic [DB_W-1:0] DB_LAST = DB_W'(DEBOUNCE_TICKS - 1);

  kpe_state_e        state_q;
  logic [DB_W-1:0]   db_q;
  logic [ROW_W-1:0]  lock_q;
  logic [CODE_W-1:0] code_q;
  logic              dav_q;

  logic              any_low;
  logic [ROW_W-1:0]  first_low;
  logic              lock_low;

  // lowest-numbered low row wins
  always_comb begin
    first_low = '0;
    for (int r = NUM_ROWS - 1; r >= 0; r--) begin
      if (!row_s_ni[r]) first_low = ROW_W'(r);
    end
  end

  always_comb begin
    lock_low = 1'b0;
    for (int r = 0; r < NUM_ROWS; r++) begin
      if (lock_q == ROW_W'(r)) lock_low = !row_s_ni[r];
    end
  end

  assign any_low = !(&row_s_ni);
  assign adv_o   = tick_i && (state_q == ST_SCAN) && !any_low;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SCAN;
      db_q    <= '0;
      lock_q  <= '0;
      code_q  <= '0;
      dav_q   <= 1'b0;
    end else if (tick_i) begin
      unique case (state_q)
        ST_SCAN: begin
          if (any_low) begin
            lock_q  <= first_low;
            db_q    <= '0;
            state_q <= ST_PRESS;
          end
        end
        ST_PRESS: begin
          if (!lock_low) begin
            state_q <= ST_SCAN;
          end else if (db_q == DB_LAST) begin
            code_q  <= {lock_q, col_idx_i};
            dav_q   <= 1'b1;
            state_q <= ST_HELD;
          end else begin
            db_q <= db_q + 1'b1;
          end
        end
        ST_HELD: begin
          if (!lock_low) begin
            db_q    <= '0;
            state_q <= ST_RELEASE;
          end
        end
        ST_RELEASE: begin
          if (lock_low) begin
            state_q <= ST_HELD;
          end else if (db_q == DB_LAST) begin
            dav_q   <= 1'b0;
            state_q <= ST_SCAN;
          end else begin
            db_q <= db_q + 1'b1;
          end
        end
        default: state_q <= ST_SCAN;
      endcase
    end
  end

  assign state_o    = state_q;
  assign lock_row_o = lock_q;
  assign code_o     = code_q;
  assign dav_o      = dav_q;
endmodule

// File: rtl/keypad_encoder.sv
module keypad_encoder
  import kpe_pkg::*;
#(
  parameter int unsigned NUM_ROWS       = 5,
  parameter int unsigned TICK_DIV       = 4,
  parameter int unsigned DEBOUNCE_TICKS = 3,
  localparam int unsigned CODE_W        = (NUM_ROWS > 4) ? 5 : 4,
  localparam int unsigned ROW_W         = CODE_W - COL_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_ROWS-1:0] row_ni,
  output logic [3:0]          col_no,
  input  logic                oe_ni,
  output logic [CODE_W-1:0]   code_o,
  output logic                code_valid_o,
  output logic                dav_o
);
  logic                tick;
  logic                adv;
  logic [NUM_ROWS-1:0] row_s;
  logic [COL_W-1:0]    col_idx;
  kpe_state_e          ctrl_state;
  logic [ROW_W-1:0]    lock_row;
  logic [CODE_W-1:0]   code_q;

  kpe_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  kpe_row_sync #(.NUM_ROWS(NUM_ROWS)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .row_ni  (row_ni),
    .row_s_no(row_s)
  );

  kpe_col_scan u_scan (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (adv),
    .col_idx_o(col_idx),
    .col_no   (col_no)
  );

  kpe_ctrl #(
    .NUM_ROWS      (NUM_ROWS),
    .DEBOUNCE_TICKS(DEBOUNCE_TICKS),
    .CODE_W        (CODE_W),
    .ROW_W         (ROW_W)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .row_s_ni  (row_s),
    .col_idx_i (col_idx),
    .adv_o     (adv),
    .state_o   (ctrl_state),
    .lock_row_o(lock_row),
    .code_o    (code_q),
    .dav_o     (dav_o)
  );

  assign code_valid_o = !oe_ni;
  assign code_o       = oe_ni ? 'z : code_q;
endmodule

// File: rtl/kpe_checker.sv
module kpe_checker
  import kpe_pkg::*;
#(
  parameter int unsigned NUM_ROWS = 5,
  parameter int unsigned CODE_W   = 5,
  parameter int unsigned ROW_W    = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [3:0]        col_no,
  input logic              dav_o,
  input kpe_state_e        state_i,
  input logic [ROW_W-1:0]  lock_row_i,
  input logic [CODE_W-1:0] code_q_i
);
  p_one_col_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~col_no) == 1);

  p_col_frozen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != ST_SCAN) && ($past(state_i) != ST_SCAN) |-> $stable(col_no));

  p_lock_in_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != ST_SCAN) |-> (int'(lock_row_i) < NUM_ROWS));

  p_dav_after_debounce_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dav_o) |-> (state_i == ST_HELD) && ($past(state_i) == ST_PRESS));

  p_dav_low_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_SCAN) || (state_i == ST_PRESS) |-> !dav_o);

  p_code_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != ST_PRESS) |=> $stable(code_q_i));
endmodule

bind keypad_encoder kpe_checker #(
  .NUM_ROWS(NUM_ROWS),
  .CODE_W  (CODE_W),
  .ROW_W   (ROW_W)
) u_kpe_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .col_no    (col_no),
  .dav_o     (dav_o),
  .state_i   (ctrl_state),
  .lock_row_i(lock_row),
  .code_q_i  (code_q)
);

// File: tb/keypad_encoder_bench.sv
`timescale 1ns/1ps
module keypad_encoder_bench;
  localparam int NR  = 5;
  localparam int TD  = 4;
  localparam int DEB = 3;
  localparam int CW  = 5;
  localparam int MAXLAT = (6 + DEB) * TD + 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NR-1:0] row_n;
  logic [3:0]    col_n;
  logic          oe_n = 1'b0;
  logic [CW-1:0] code;
  logic          code_valid;
  logic          dav;
  logic [3:0]    key_mat [NR];

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  // keypad model: a row reads low when a pressed key sits on the driven column
  always_comb begin
    for (int r = 0; r < NR; r++) row_n[r] = !(|(key_mat[r] & ~col_n));
  end

  keypad_encoder #(.NUM_ROWS(NR), .TICK_DIV(TD), .DEBOUNCE_TICKS(DEB)) u_keypad_encoder (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .row_ni      (row_n),
    .col_no      (col_n),
    .oe_ni       (oe_n),
    .code_o      (code),
    .code_valid_o(code_valid),
    .dav_o       (dav)
  );

  function automatic int exp_code(int r, int c);
    return r * 4 + c;
  endfunction

  function automatic logic [3:0] col_drive(int c);
    return ~(4'b0001 << c);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clear_keys();
    for (int r = 0; r < NR; r++) key_mat[r] = 4'b0000;
  endtask

  task automatic wait_dav(logic lvl, int maxc, output int n);
    n = 0;
    while (dav !== lvl && n < maxc) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic press_and_check(int r, int c, string req);
    int n;
    @(negedge clk);
    key_mat[r][c] = 1'b1;
    wait_dav(1'b1, MAXLAT, n);
    chk(dav === 1'b1, {req, " dav rise"}, dav, 1);
    chk(n >= DEB * TD, "R6 min latency", n, DEB * TD);
    chk(code === CW'(exp_code(r, c)), {req, " code"}, code, exp_code(r, c));
  endtask

  task automatic release_and_check(int r, int c);
    int n;
    int last;
    last = exp_code(r, c);
    @(negedge clk);
    key_mat[r][c] = 1'b0;
    wait_dav(1'b0, MAXLAT, n);
    chk(dav === 1'b0, "R7 dav fall", dav, 0);
    chk(n >= DEB * TD, "R7 release latency", n, DEB * TD);
    repeat (3) @(negedge clk);
    chk(code === CW'(last), "R8 code held after release", code, last);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int n;
    int r0;
    int c0;
    logic [3:0] cur;
    bit ok;
    bit stuck;
    clear_keys();
    void'($urandom(32'd1234));

    // R10 reset state
    repeat (3) @(negedge clk);
    chk(col_n === 4'b1110, "R10 col reset", col_n, 4'b1110);
    chk(dav === 1'b0, "R10 dav reset", dav, 0);
    chk(code === '0, "R10 code reset", code, 0);
    rst_n = 1'b1;

    // R2 idle rotation
    cur = col_n;
    for (int i = 0; i < 8; i++) begin
      n = 0;
      while (col_n === cur && n < 4 * TD) begin
        @(negedge clk);
        n++;
      end
      ok = 1'b0;
      for (int c = 0; c < 4; c++) if (cur == col_drive(c) && col_n == col_drive((c + 1) % 4)) ok = 1'b1;
      chk(ok, "R2 rotation order", col_n, cur);
      if (i > 0) chk(n == TD, "R2 rotation period", n, TD);
      cur = col_n;
    end

    // R1/R6 corner keys
    press_and_check(0, 0, "R1 key0");
    release_and_check(0, 0);
    press_and_check(NR - 1, 3, "R1 last key");

    // R3 column frozen while held
    cur = col_n;
    ok = 1'b1;
    repeat (5 * TD) begin
      @(negedge clk);
      if (col_n !== cur) ok = 1'b0;
    end
    chk(ok && cur == col_drive(3), "R3 column frozen", col_n, col_drive(3));
    release_and_check(NR - 1, 3);

    // R5 closure bounce never latches
    stuck = 1'b0;
    for (int b = 0; b < 10; b++) begin
      key_mat[2][1] = 1'b1;
      repeat ((DEB - 1) * TD) begin
        @(negedge clk);
        if (dav) stuck = 1'b1;
      end
      key_mat[2][1] = 1'b0;
      repeat (TD + b) begin
        @(negedge clk);
        if (dav) stuck = 1'b1;
      end
    end
    chk(!stuck, "R5 short closures ignored", stuck, 0);
    press_and_check(2, 1, "R5 steady after bounce");

    // R7 release bounce keeps dav, no new code
    @(negedge clk);
    key_mat[2][1] = 1'b0;
    ok = 1'b1;
    repeat ((DEB - 1) * TD) begin
      @(negedge clk);
      if (!dav) ok = 1'b0;
    end
    key_mat[2][1] = 1'b1;
    repeat (4 * TD) begin
      @(negedge clk);
      if (!dav) ok = 1'b0;
    end
    chk(ok, "R7 release bounce keeps dav", dav, 1);
    chk(code === CW'(exp_code(2, 1)), "R7 code unchanged", code, exp_code(2, 1));
    release_and_check(2, 1);

    // R4 rollover: B pressed while A held
    press_and_check(1, 2, "R4 first key");
    @(negedge clk);
    key_mat[3][0] = 1'b1;
    ok = 1'b1;
    repeat (10 * TD) begin
      @(negedge clk);
      if (!dav || code !== CW'(exp_code(1, 2)) || col_n !== col_drive(2)) ok = 1'b0;
    end
    chk(ok, "R4 second key locked out", code, exp_code(1, 2));
    key_mat[1][2] = 1'b0;
    wait_dav(1'b0, MAXLAT, n);
    chk(dav === 1'b0, "R4 first released", dav, 0);
    wait_dav(1'b1, MAXLAT, n);
    chk(dav === 1'b1 && code === CW'(exp_code(3, 0)), "R4 second key after rollover", code, exp_code(3, 0));
    release_and_check(3, 0);

    // R4 two rows in one column: lowest row wins
    @(negedge clk);
    key_mat[4][1] = 1'b1;
    key_mat[2][1] = 1'b1;
    wait_dav(1'b1, MAXLAT, n);
    chk(code === CW'(exp_code(2, 1)), "R4 row priority", code, exp_code(2, 1));
    clear_keys();
    wait_dav(1'b0, 2 * MAXLAT, n);
    wait_dav(1'b1, MAXLAT, n);
    chk(dav === 1'b0, "R4 no ghost after release", dav, 0);

    // R9 output enable
    @(negedge clk);
    oe_n = 1'b1;
    #1;
    chk(code_valid === 1'b0, "R9 valid low when disabled", code_valid, 0);
    @(negedge clk);
    oe_n = 1'b0;
    #1;
    chk(code_valid === 1'b1, "R9 valid high when enabled", code_valid, 1);
    chk(code === CW'(exp_code(2, 1)), "R9 code driven", code, exp_code(2, 1));

    // random keys, R1 across the code space
    for (int i = 0; i < 24; i++) begin
      r0 = int'($urandom_range(NR - 1, 0));
      c0 = int'($urandom_range(3, 0));
      press_and_check(r0, c0, "R1 random key");
      repeat ($urandom_range(3 * TD, 0)) @(negedge clk);
      release_and_check(r0, c0);
      repeat ($urandom_range(2 * TD, 0)) @(negedge clk);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule